// File: doc/BRIEF.md
# Bipolar Line Decoder for B3ZS and HDB3 with Violation Flag

This block sits on the receive side of a high-speed copper line interface, behind the clock and data recovery. Each bit slot delivers a pair of rail bits: `rail_p` high means a positive mark, `rail_n` high means a negative mark, and both low means a space. A `bit_en` strobe marks each slot. In decode mode the block turns the bipolar stream back into NRZ data. It removes the zero-substitution patterns that the far-end encoder inserted, and it raises a one-slot flag for each line-code error it finds.

Two static inputs set the operation. `code_b3zs` selects the substitution code: high selects three-zero substitution (B3ZS), whose patterns are B0V and 00V; low selects four-zero substitution (HDB3), whose patterns are B00V and 000V. `nrz_mode` selects between the decoder and a transparent path. When `nrz_mode` is low, the two rails pass straight to the two outputs.

Both paths share one four-slot alignment pipeline. The decoder can therefore reach back to a substitution B pulse that has already entered the pipeline, and the data and flag for any bit always leave together.

Top module: `b3hd_decoder`

## Requirements
- R1: With `nrz_mode` low, `data_out` equals `rail_p` and `flag_out` equals `rail_n` of the slot captured four `bit_en` strobes earlier, with no decoding, including slots where both rails are high.
- R2: With `nrz_mode` high, `data_out` carries decoded NRZ data and `flag_out` carries the violation flag, both aligned to the slot captured four `bit_en` strobes earlier; a space that ends no excessive run decodes as 0 with no flag.
- R3: Outputs and all tracking state change only on clock edges where `bit_en` is high; rail values on other cycles have no effect, so a flag lasts exactly one bit slot.
- R4: A valid substitution is removed and decodes as all zeros with no flag. In B3ZS the valid forms are B0V when the mark count since the last V is even, and 00V when it is odd. In HDB3 the valid forms are B00V when that count is even, and 000V when it is odd. Here V has the same polarity as the preceding mark, and B is a normal alternating mark.
- R5: A mark with the same polarity as the previous mark that is neither a valid substitution nor a code violation is a bipolar violation: it decodes as 1 and is flagged in its own slot (for example B,V in either code, or B,0,V in HDB3).
- R6: A same-polarity mark that follows exactly two spaces (B3ZS) or three spaces (HDB3), when the mark count since the last V is even, is a code violation: it decodes as 1 and is flagged in its own slot.
- R7: The third consecutive space (B3ZS) or the fourth consecutive space (HDB3) is flagged and decodes as 0; the later spaces of the same run are not flagged.
- R8: `code_b3zs` high selects B3ZS rules; low selects HDB3 rules. A stream encoded with the selected code decodes back to its original data.
- R9: While `rst_n` is low, both outputs are 0. Reset leaves the last-mark polarity negative, the mark-count parity even and the space run at zero, so a first positive mark is normal and a first negative mark is a violation.
- R10: Each normal alternating mark decodes as 1 with no flag and toggles the mark-count parity. Any same-polarity mark, valid or not, clears the parity to even. Every single-rail mark sets the last-mark polarity to its own sign.
- R11: A slot with both rails high decodes as 1 and is flagged. It leaves the last-mark polarity and the parity unchanged, clears the space run, and cannot act as the B pulse of a later substitution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe marking a valid bit slot |
| rail_p | input | 1 | Positive-mark rail |
| rail_n | input | 1 | Negative-mark rail |
| nrz_mode | input | 1 | 1 = decode, 0 = transparent rails |
| code_b3zs | input | 1 | 1 = B3ZS rules, 0 = HDB3 rules |
| data_out | output | 1 | Decoded data, or the positive rail when transparent |
| flag_out | output | 1 | Violation flag, or the negative rail when transparent |

## Verification
The bench encodes random data with its own encoder for each code and expects the original bits back. A design that cleared the wrong pipeline slot for a B pulse, or that got the parity choice wrong, would show extra ones or spurious flags in those runs.

Directed sequences then target the cases that are easy to confuse:
- B,0,V in HDB3 must be flagged but not removed.
- Spaces followed by V with even parity must be a code error, not a substitution.
- An excessive zero run must be flagged only on its limit space.
- A double-rail slot must not disturb the polarity tracking.

Both rails carry noise between strobes, so a design that sampled without `bit_en` would corrupt the data. The first mark after reset separates a design whose reset polarity is wrong.

// File: rtl/b3hd_pkg.sv
package b3hd_pkg;

  localparam int ZRUN_W   = 3;
  localparam int ZRUN_MAX = 4;

  typedef enum logic [1:0] {
    SYM_SPACE = 2'b00,
    SYM_POS   = 2'b01,
    SYM_NEG   = 2'b10,
    SYM_BOTH  = 2'b11
  } sym_e;

  typedef enum logic [2:0] {
    EV_SPACE       = 3'd0,
    EV_ZERO_ERR    = 3'd1,
    EV_MARK        = 3'd2,
    EV_SUB_FULL    = 3'd3,
    EV_SUB_PAIR    = 3'd4,
    EV_CODE_ERR    = 3'd5,
    EV_BIPOLAR_ERR = 3'd6,
    EV_DOUBLE_RAIL = 3'd7
  } ev_e;

  // Spaces that precede V in the all-space substitution form.
  function automatic logic [ZRUN_W-1:0] fill_zeros(input logic b3zs);
    return b3zs ? ZRUN_W'(2) : ZRUN_W'(3);
  endfunction

  function automatic sym_e to_sym(input logic p, input logic n);
    return sym_e'({n, p});
  endfunction

  function automatic ev_e classify(input sym_e s, input logic last_pos,
                                   input logic par_odd,
                                   input logic [ZRUN_W-1:0] zrun,
                                   input logic last_norm, input logic b3zs);
    logic [ZRUN_W-1:0] z;
    logic same_pol;
    z = fill_zeros(b3zs);
    same_pol = ((s == SYM_POS) == last_pos);
    if (s == SYM_SPACE) return (zrun == z) ? EV_ZERO_ERR : EV_SPACE;
    if (s == SYM_BOTH) return EV_DOUBLE_RAIL;
    if (!same_pol) return EV_MARK;
    if ((zrun == z) && par_odd) return EV_SUB_FULL;
    if ((zrun == z - ZRUN_W'(1)) && par_odd && last_norm) return EV_SUB_PAIR;
    if ((zrun == z) && !par_odd) return EV_CODE_ERR;
    return EV_BIPOLAR_ERR;
  endfunction

  function automatic logic ev_data(input ev_e e);
    return (e == EV_MARK) || (e == EV_CODE_ERR) ||
           (e == EV_BIPOLAR_ERR) || (e == EV_DOUBLE_RAIL);
  endfunction

  function automatic logic ev_flag(input ev_e e);
    return (e == EV_ZERO_ERR) || (e == EV_CODE_ERR) ||
           (e == EV_BIPOLAR_ERR) || (e == EV_DOUBLE_RAIL);
  endfunction

  function automatic logic ev_is_sub(input ev_e e);
    return (e == EV_SUB_FULL) || (e == EV_SUB_PAIR);
  endfunction

endpackage

// File: rtl/b3hd_zero_run.sv
module b3hd_zero_run #(
  parameter int CNT_W   = 3,
  parameter int CNT_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             is_space,
  output logic [CNT_W-1:0] zrun
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun <= '0;
    end else if (bit_en) begin
      if (!is_space) zrun <= '0;
      else if (zrun != SAT) zrun <= zrun + CNT_W'(1);
    end
  end

  AST_ZRUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= SAT);  // R7

  AST_ZRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !is_space |=> zrun == '0);  // R11

endmodule

// File: rtl/b3hd_classifier.sv
module b3hd_classifier
  import b3hd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              b3zs,
  input  sym_e              sym,
  input  logic [ZRUN_W-1:0] zrun,
  output ev_e               ev
);

  logic last_pos;   // polarity of last single-rail mark, 1 = positive
  logic par_odd;    // marks since last V, modulo 2
  logic last_norm;  // last mark was a normal alternating mark
  logic same_pol_mark;

  assign ev = classify(sym, last_pos, par_odd, zrun, last_norm, b3zs);
  assign same_pol_mark = ((sym == SYM_POS) || (sym == SYM_NEG)) &&
                         ((sym == SYM_POS) == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos  <= 1'b0;
      par_odd   <= 1'b0;
      last_norm <= 1'b0;
    end else if (bit_en) begin
      case (ev)
        EV_MARK: begin
          last_pos  <= (sym == SYM_POS);
          par_odd   <= ~par_odd;
          last_norm <= 1'b1;
        end
        EV_SUB_FULL, EV_SUB_PAIR, EV_CODE_ERR, EV_BIPOLAR_ERR: begin
          last_pos  <= (sym == SYM_POS);
          par_odd   <= 1'b0;
          last_norm <= 1'b0;
        end
        EV_DOUBLE_RAIL: last_norm <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_VIOL_CLEARS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && same_pol_mark |=> !par_odd);  // R10

  AST_NEG_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && (sym == SYM_NEG) |=> !last_pos);  // R10

  AST_DOUBLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && (sym == SYM_BOTH) |=> $stable(last_pos) && $stable(par_odd));  // R11

  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(last_pos) && $stable(par_odd) && $stable(last_norm));  // R3

endmodule

// File: rtl/b3hd_align_pipe.sv
module b3hd_align_pipe #(
  parameter int DEPTH    = 4,
  parameter int POS_NEAR = 2,
  parameter int POS_FAR  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic d_in,
  input  logic f_in,
  input  logic clr_near,
  input  logic clr_far,
  output logic head_d,
  output logic head_f,
  output logic d_out,
  output logic f_out
);

  logic [DEPTH-1:0] d_q;
  logic [DEPTH-1:0] f_q;
  logic [DEPTH-1:0] kill;

  for (genvar k = 0; k < DEPTH; k++) begin : g_kill
    assign kill[k] = ((k == POS_NEAR) && clr_near) || ((k == POS_FAR) && clr_far);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      f_q <= '0;
    end else if (bit_en) begin
      d_q <= {d_q[DEPTH-2:0], d_in} & ~kill;
      f_q <= {f_q[DEPTH-2:0], f_in};
    end
  end

  assign head_d = d_q[0];
  assign head_f = f_q[0];
  assign d_out  = d_q[DEPTH-1];
  assign f_out  = f_q[DEPTH-1];

  AST_NEAR_CLEARS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && clr_near |-> d_q[POS_NEAR-1]);  // R4

  AST_FAR_CLEARS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && clr_far |-> d_q[POS_FAR-1]);  // R4

endmodule

// File: rtl/b3hd_decoder.sv
module b3hd_decoder
  import b3hd_pkg::*;
#(
  parameter int PIPE_DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rail_p,
  input  logic rail_n,
  input  logic nrz_mode,
  input  logic code_b3zs,
  output logic data_out,
  output logic flag_out
);

  localparam int POS_B3  = int'(fill_zeros(1'b1));
  localparam int POS_HDB = int'(fill_zeros(1'b0));

  sym_e              sym;
  ev_e               ev;
  logic [ZRUN_W-1:0] zrun;
  logic              dec_d, dec_f;
  logic              pipe_d, pipe_f;
  logic              clr_near, clr_far;
  logic              head_d, head_f;

  assign sym = to_sym(rail_p, rail_n);

  b3hd_zero_run #(.CNT_W(ZRUN_W), .CNT_MAX(ZRUN_MAX)) u_zrun (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .is_space (sym == SYM_SPACE),
    .zrun     (zrun)
  );

  b3hd_classifier u_cls (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .b3zs   (code_b3zs),
    .sym    (sym),
    .zrun   (zrun),
    .ev     (ev)
  );

  assign dec_d    = ev_data(ev);
  assign dec_f    = ev_flag(ev);
  assign pipe_d   = nrz_mode ? dec_d : rail_p;
  assign pipe_f   = nrz_mode ? dec_f : rail_n;
  assign clr_near = nrz_mode && (ev == EV_SUB_PAIR) && code_b3zs;
  assign clr_far  = nrz_mode && (ev == EV_SUB_PAIR) && !code_b3zs;

  b3hd_align_pipe #(.DEPTH(PIPE_DEPTH), .POS_NEAR(POS_B3), .POS_FAR(POS_HDB)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .d_in     (pipe_d),
    .f_in     (pipe_f),
    .clr_near (clr_near),
    .clr_far  (clr_far),
    .head_d   (head_d),
    .head_f   (head_f),
    .d_out    (data_out),
    .f_out    (flag_out)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(data_out) && $stable(flag_out));  // R3

  AST_SUB_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_mode && bit_en && ev_is_sub(ev) |=> !head_d && !head_f);  // R4

  AST_EXCESS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_mode && bit_en && (ev == EV_ZERO_ERR) |=> head_f && !head_d);  // R7

  AST_PASS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    !nrz_mode && bit_en |=> (head_d == $past(rail_p)) && (head_f == $past(rail_n)));  // R1

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !data_out && !flag_out);  // R9

endmodule

// File: tb/b3hd_decoder_bench.sv
module b3hd_decoder_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic rail_p = 1'b0;
  logic rail_n = 1'b0;
  logic nrz_mode = 1'b0;
  logic code_b3zs = 1'b0;
  logic data_out, flag_out;

  logic  qd[$];
  logic  qf[$];
  string qt[$];

  int   checks = 0;
  int   fails = 0;
  int   edges = 0;
  logic en_seen = 1'b0;
  logic prev_d = 1'b0;
  logic prev_f = 1'b0;
  bit   done = 1'b0;

  // Bench reference state for the decoder.
  int m_last, m_cnt, m_zeros;
  bit m_norm;

  b3hd_decoder u_b3hd_decoder (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rail_p(rail_p), .rail_n(rail_n),
    .nrz_mode(nrz_mode), .code_b3zs(code_b3zs), .data_out(data_out), .flag_out(flag_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: data/flag got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) en_seen <= bit_en && rst_n;

  // Monitor: pop one expected item per strobe once the pipeline is full.
  always @(negedge clk) begin
    logic  ed, ef;
    string et;
    if (rst_n && !done) begin
      if (en_seen) begin
        edges++;
        if (edges >= 4 && qd.size() > 0) begin
          ed = qd.pop_front();
          ef = qf.pop_front();
          et = qt.pop_front();
          if (et != "")
            chk((data_out === ed) && (flag_out === ef), et, {data_out, flag_out}, {ed, ef});
        end
      end else begin
        chk((data_out === prev_d) && (flag_out === prev_f), "R3",
            {data_out, flag_out}, {prev_d, prev_f});
      end
      prev_d = data_out;
      prev_f = flag_out;
    end
  end

  // One bit slot; optional idle cycles carry rail noise that must be ignored (R3).
  task automatic bit_slot(input logic p, input logic n, input logic d, input logic f,
                          input string tag, input int gap);
    rail_p = p;
    rail_n = n;
    bit_en = 1'b1;
    qd.push_back(d);
    qf.push_back(f);
    qt.push_back(tag);
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (gap > 0) begin
      bit_en = 1'b0;
      repeat (gap) begin
        rail_p = 1'($urandom);
        rail_n = 1'($urandom);
        @(posedge clk);
        #(CLK_PERIOD/4);
      end
    end
  endtask

  task automatic do_reset(input logic nrz, input logic b3);
    rst_n = 1'b0;
    bit_en = 1'b0;
    rail_p = 1'b0;
    rail_n = 1'b0;
    nrz_mode = nrz;
    code_b3zs = b3;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    chk(!data_out && !flag_out, "R9", {data_out, flag_out}, 2'b00);
    qd.delete();
    qf.delete();
    qt.delete();
    edges = 0;
    prev_d = 1'b0;
    prev_f = 1'b0;
    m_last = -1;
    m_cnt = 0;
    m_zeros = 0;
    m_norm = 0;
    rst_n = 1'b1;
  endtask

  task automatic drain();
    repeat (4) bit_slot(1'b0, 1'b0, 1'b0, 1'b0, "", 0);
  endtask

  // Decode one symbol through the bench reference rules.
  task automatic dec(input logic p, input logic n, input int gap);
    int    z, pol;
    logic  d, f;
    string tag;
    z = code_b3zs ? 2 : 3;
    if (p && n) begin
      d = 1; f = 1; tag = "R11";
      m_zeros = 0; m_norm = 0;
    end else if (!p && !n) begin
      m_zeros++;
      d = 0;
      f = (m_zeros == z + 1);
      tag = f ? "R7" : "R2";
    end else begin
      pol = p ? 1 : -1;
      if (pol != m_last) begin
        d = 1; f = 0; tag = "R10";
        m_cnt ^= 1;
        m_norm = 1;
      end else begin
        if (m_zeros == z && m_cnt == 1) begin
          d = 0; f = 0; tag = "R4";
        end else if (m_zeros == z - 1 && m_norm && m_cnt == 1) begin
          d = 0; f = 0; tag = "R4";
          if (qd.size() >= z) begin
            qd[qd.size() - z] = 1'b0;
            qt[qt.size() - z] = "R4";
          end
        end else if (m_zeros == z && m_cnt == 0) begin
          d = 1; f = 1; tag = "R6";
        end else begin
          d = 1; f = 1; tag = "R5";
        end
        m_cnt = 0;
        m_norm = 0;
      end
      m_last = pol;
      m_zeros = 0;
    end
    bit_slot(p, n, d, f, tag, gap);
  endtask

  task automatic emit(input int pol, input logic d, input string tag);
    bit_slot(pol > 0, pol < 0, d, 1'b0, tag, ($urandom_range(0, 3) == 0) ? 1 : 0);
  endtask

  // Bench encoder for the selected code; expects the original data back (R8, R4).
  task automatic run_encoded(input int nbits);
    int w, e_last, e_odd, i, b;
    bit all0;
    bit data[];
    w = code_b3zs ? 3 : 4;
    data = new[nbits];
    for (int k = 0; k < nbits; k++) data[k] = ($urandom_range(0, 2) == 0);
    e_last = -1;
    e_odd = 0;
    i = 0;
    while (i < nbits) begin
      all0 = (i + w <= nbits);
      for (int k = 0; k < w; k++)
        if (i + k < nbits && data[i + k]) all0 = 0;
      if (all0) begin
        if (e_odd == 1) begin
          for (int k = 0; k < w - 1; k++) emit(0, 1'b0, "R4");
          emit(e_last, 1'b0, "R4");
        end else begin
          b = -e_last;
          emit(b, 1'b0, "R4");
          for (int k = 0; k < w - 2; k++) emit(0, 1'b0, "R4");
          emit(b, 1'b0, "R4");
          e_last = b;
        end
        e_odd = 0;
        i += w;
      end else if (data[i]) begin
        e_last = -e_last;
        e_odd ^= 1;
        emit(e_last, 1'b1, "R8");
        i++;
      end else begin
        emit(0, 1'b0, "R8");
        i++;
      end
    end
  endtask

  task automatic run_random(input int n);
    int r;
    for (int k = 0; k < n; k++) begin
      r = $urandom_range(0, 9);
      if (r < 5)      dec(1'b0, 1'b0, $urandom_range(0, 1));
      else if (r < 7) dec(1'b1, 1'b0, 0);
      else if (r < 9) dec(1'b0, 1'b1, 0);
      else            dec(1'b1, 1'b1, 0);
    end
  endtask

  initial begin
    logic p, n;

    // R1: transparent rails, including double-rail slots.
    do_reset(1'b0, 1'b1);
    for (int k = 0; k < 40; k++) begin
      p = 1'($urandom);
      n = 1'($urandom);
      bit_slot(p, n, p, n, "R1", $urandom_range(0, 2));
    end
    drain();

    // R9: the first negative mark after reset is a violation; positive is normal.
    do_reset(1'b1, 1'b1);
    dec(1'b0, 1'b1, 0);
    dec(1'b1, 1'b0, 0);
    drain();

    // B3ZS directed cases.
    do_reset(1'b1, 1'b1);
    dec(1'b1, 1'b0, 0);                                  // normal mark
    dec(1'b1, 1'b0, 1);                                  // B,V -> R5
    dec(1'b0, 1'b0, 0); dec(1'b0, 1'b0, 0);
    dec(1'b1, 1'b0, 0);                                  // 0,0,V even -> R6
    dec(1'b0, 1'b0, 0); dec(1'b0, 1'b0, 0);
    dec(1'b0, 1'b0, 2); dec(1'b0, 1'b0, 0);              // run of 4 -> R7 once
    dec(1'b0, 1'b1, 0);
    dec(1'b0, 1'b0, 0); dec(1'b0, 1'b1, 0);              // B0V -> R4
    dec(1'b1, 1'b1, 0);                                  // R11
    dec(1'b0, 1'b1, 0);                                  // same as last -> R5
    dec(1'b1, 1'b0, 0);
    dec(1'b0, 1'b0, 0); dec(1'b0, 1'b0, 0);
    dec(1'b1, 1'b0, 0);                                  // 00V odd -> R4
    drain();

    // HDB3 directed cases.
    do_reset(1'b1, 1'b0);
    dec(1'b1, 1'b0, 0);
    dec(1'b0, 1'b0, 0); dec(1'b1, 1'b0, 0);              // B,0,V -> R5
    dec(1'b0, 1'b0, 0); dec(1'b0, 1'b0, 0); dec(1'b0, 1'b0, 0);
    dec(1'b1, 1'b0, 0);                                  // 0,0,0,V even -> R6
    for (int k = 0; k < 5; k++) dec(1'b0, 1'b0, 0);      // R7 on fourth only
    dec(1'b0, 1'b1, 0);
    dec(1'b0, 1'b0, 0); dec(1'b0, 1'b0, 0); dec(1'b0, 1'b1, 0);  // B00V -> R4
    dec(1'b1, 1'b0, 0);
    dec(1'b0, 1'b0, 0); dec(1'b0, 1'b0, 0); dec(1'b0, 1'b0, 0);
    dec(1'b1, 1'b0, 0);                                  // 000V odd -> R4
    dec(1'b1, 1'b1, 0);
    dec(1'b0, 1'b1, 0);                                  // R11 kept polarity positive
    drain();

    // R8: encoded streams decode back to the data.
    do_reset(1'b1, 1'b1);
    run_encoded(300);
    drain();
    do_reset(1'b1, 1'b0);
    run_encoded(300);
    drain();

    // Random symbol streams under each code.
    do_reset(1'b1, 1'b1);
    run_random(400);
    drain();
    do_reset(1'b1, 1'b0);
    run_random(400);
    drain();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung, got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule